// File: doc/BRIEF.md
# Latched-Address Memory Chip-Select Decoder

This block sits beside a processor whose low address byte shares pins with the data bus and whose upper address bits are only valid during the address phase. While the address strobe is high it captures all twenty address bits. When the strobe falls it holds that value for the rest of the bus cycle. It then decodes the held address into active-low selects for three kinds of device: a RAM, a bank of eight 16 KB ROMs, and a 16 KB boot ROM. It also produces memory read and write commands that assert only when the I/O-or-memory line marks a memory cycle.

The build-time parameter `PARTIAL_DECODE` picks the decoding scheme. With full decoding every relevant upper address line is compared, so each device occupies exactly one window. With partial decoding the RAM shrinks to 64 KB, and some lines are left out of each compare. Each device then answers at mirror addresses, and the comparators are smaller.

All selects and commands are registered. They change one clock after the command is sampled and never while the strobe is high. This keeps them free of glitches during the multiplexed data phase.

Top module: `busmem_select`

## Requirements
- R1: While `rst` is high, every select output and both command outputs are driven high (inactive). The latched address, RAM address and ROM offset all read zero.
- R2: A select or a command can assert only when `io_mem` is 0. The read command `mem_rd_n` follows `rd_n` low and the write command `mem_wr_n` follows `wr_n` low. When `io_mem` is 1, all outputs stay high.
- R3: Full mode: `ram_sel_n` asserts for addresses whose bits 19 and 18 are both 0 (00000h–3FFFFh). `ram_addr` carries address bits 17..0.
- R4: Full mode: the ROM bank is enabled only when bits 19..17 equal 100b. Bits 16..14 then pick `bank_sel_n[i]` for i equal to that 3-bit value (80000h–9FFFFh).
- R5: Full mode: `boot_sel_n` asserts only when bits 19..14 are all 1 (FC000h–FFFFFh). `rom_offset` carries bits 13..0.
- R6: Partial mode: the RAM select ignores bits 17 and 16, so the RAM repeats four times in 00000h–3FFFFh. `ram_addr` carries bits 15..0, with its two top bits forced to 0.
- R7: Partial mode: the ROM bank enable ignores bit 18 and needs only bit 19 = 1 and bit 17 = 0, so each bank ROM also appears in C0000h–DFFFFh.
- R8: Partial mode: the boot select ignores bit 19 and needs bits 18..14 all 1, so the boot ROM mirrors at 7C000h–7FFFFh.
- R9: If `rd_n` and `wr_n` are both high, every select and command is high at the next clock.
- R10: The address register loads `{a_hi, ad_lo}` on each clock while `ale` is high. It holds that value unchanged while `ale` is low, whatever appears on the multiplexed pins.
- R11: At most one select (RAM, any bank ROM, boot) is low at any time.
- R12: Outputs are registered. A clock edge that samples `ale` high drives every select and command inactive. Selects for an address appear at the first edge that samples `ale` low together with an active command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe, high during the address phase |
| ad_lo | input | 8 | Multiplexed address/data low byte |
| a_hi | input | 12 | Address bits 19..8 |
| io_mem | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| lat_addr | output | 20 | Held address |
| ram_addr | output | 18 | Address offset into the RAM |
| rom_offset | output | 14 | Address offset into any 16 KB ROM |
| ram_sel_n | output | 1 | RAM select, active low |
| bank_sel_n | output | 8 | Bank ROM selects, active low |
| boot_sel_n | output | 1 | Boot ROM select, active low |
| mem_rd_n | output | 1 | Qualified memory read, active low |
| mem_wr_n | output | 1 | Qualified memory write, active low |

## Verification
Both build modes run side by side on the same stimulus. Each bus cycle puts the complement of the address on the multiplexed pins during the data phase. A latch that stayed transparent would then move the selects to the wrong device, and the bench would see it.

The bench probes the mirror windows: C4000h, DC055h and 7C010h, and RAM addresses with bits 17 and 16 set. A design that mixed up the two decoding schemes would select a device in full mode that should stay idle there, or leave the mirror dead in partial mode. A0000h must select nothing in either mode. The bench also tries I/O cycles that fall inside memory windows and cycles with no command. A design that left out the qualifier would raise a select there.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
  localparam int ADDR_W      = 20;
  localparam int LO_W        = 8;
  localparam int HI_W        = ADDR_W - LO_W;
  localparam int BANK_N      = 8;
  localparam int BANK_IDX_W  = $clog2(BANK_N);
  localparam int ROM_AW      = 14;
  localparam int RAM_FULL_AW = 18;
  localparam int RAM_PART_AW = 16;

  typedef struct packed {
    logic              ram;
    logic [BANK_N-1:0] bank;
    logic              boot;
  } hit_t;
endpackage

// File: rtl/memsel_addr_latch.sv
module memsel_addr_latch
  import memsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [LO_W-1:0]   lo_in,
  input  logic [HI_W-1:0]   hi_in,
  output logic [ADDR_W-1:0] addr_q
);

  // Follows the bus while the strobe is high, freezes once it drops.
  always_ff @(posedge clk) begin
    if (rst)      addr_q <= '0;
    else if (ale) addr_q <= {hi_in, lo_in};
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(addr_q));

endmodule

// File: rtl/memsel_region_decode.sv
module memsel_region_decode
  import memsel_pkg::*;
#(
  parameter bit PARTIAL = 1'b0
) (
  input  logic [ADDR_W-1:0]      addr,
  output hit_t                   hit,
  output logic [RAM_FULL_AW-1:0] ram_addr,
  output logic [ROM_AW-1:0]      rom_offset
);

  localparam int TOP = ADDR_W - 1;

  logic                  ram_hit;
  logic                  bank_en;
  logic                  boot_hit;
  logic [BANK_IDX_W-1:0] bank_idx;
  logic [BANK_N-1:0]     bank_vec;

  assign bank_idx   = addr[ROM_AW +: BANK_IDX_W];
  assign rom_offset = addr[ROM_AW-1:0];

  generate
    if (PARTIAL) begin : g_partial
      // Mirrors: RAM drops bits 17:16, bank drops bit 18, boot drops bit 19.
      assign ram_hit  = (addr[TOP -: 2] == 2'b00);
      assign bank_en  = addr[TOP] & ~addr[TOP-2];
      assign boot_hit = &addr[TOP-1:ROM_AW];
      assign ram_addr = {{(RAM_FULL_AW-RAM_PART_AW){1'b0}}, addr[RAM_PART_AW-1:0]};
    end else begin : g_full
      assign ram_hit  = (addr[TOP -: 2] == 2'b00);
      assign bank_en  = (addr[TOP -: 3] == 3'b100);
      assign boot_hit = &addr[TOP:ROM_AW];
      assign ram_addr = addr[RAM_FULL_AW-1:0];
    end
  endgenerate

  genvar k;
  generate
    for (k = 0; k < BANK_N; k++) begin : g_bank
      assign bank_vec[k] = bank_en && (bank_idx == BANK_IDX_W'(k));
    end
  endgenerate

  assign hit = {ram_hit, bank_vec, boot_hit};

endmodule

// File: rtl/memsel_cmd_qualify.sv
module memsel_cmd_qualify
  import memsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              io_mem,
  input  logic              rd_n,
  input  logic              wr_n,
  input  hit_t              hit,
  output logic              ram_sel_n,
  output logic [BANK_N-1:0] bank_sel_n,
  output logic              boot_sel_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n
);

  logic mem_cyc, rd_go, wr_go, any_go;

  assign mem_cyc = ~io_mem & ~ale;
  assign rd_go   = mem_cyc & ~rd_n;
  assign wr_go   = mem_cyc & ~wr_n;
  assign any_go  = rd_go | wr_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_sel_n  <= 1'b1;
      bank_sel_n <= '1;
      boot_sel_n <= 1'b1;
      mem_rd_n   <= 1'b1;
      mem_wr_n   <= 1'b1;
    end else begin
      ram_sel_n  <= ~(any_go & hit.ram);
      bank_sel_n <= ~({BANK_N{any_go}} & hit.bank);
      boot_sel_n <= ~(any_go & hit.boot);
      mem_rd_n   <= ~rd_go;
      mem_wr_n   <= ~wr_go;
    end
  end

  assert_one_select_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~ram_sel_n, ~bank_sel_n, ~boot_sel_n}));

  assert_io_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    io_mem |=> (ram_sel_n && (&bank_sel_n) && boot_sel_n && mem_rd_n && mem_wr_n));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_n && wr_n) |=> (ram_sel_n && (&bank_sel_n) && boot_sel_n && mem_rd_n && mem_wr_n));

  assert_strobe_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    ale |=> (ram_sel_n && (&bank_sel_n) && boot_sel_n && mem_rd_n && mem_wr_n));

endmodule

// File: rtl/busmem_select.sv
module busmem_select
  import memsel_pkg::*;
#(
  parameter bit PARTIAL_DECODE = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ale,
  input  logic [LO_W-1:0]        ad_lo,
  input  logic [HI_W-1:0]        a_hi,
  input  logic                   io_mem,
  input  logic                   rd_n,
  input  logic                   wr_n,
  output logic [ADDR_W-1:0]      lat_addr,
  output logic [RAM_FULL_AW-1:0] ram_addr,
  output logic [ROM_AW-1:0]      rom_offset,
  output logic                   ram_sel_n,
  output logic [BANK_N-1:0]      bank_sel_n,
  output logic                   boot_sel_n,
  output logic                   mem_rd_n,
  output logic                   mem_wr_n
);

  logic [ADDR_W-1:0] addr_q;
  hit_t              hit;

  memsel_addr_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .ale    (ale),
    .lo_in  (ad_lo),
    .hi_in  (a_hi),
    .addr_q (addr_q)
  );

  memsel_region_decode #(.PARTIAL(PARTIAL_DECODE)) u_decode (
    .addr       (addr_q),
    .hit        (hit),
    .ram_addr   (ram_addr),
    .rom_offset (rom_offset)
  );

  memsel_cmd_qualify u_qualify (
    .clk        (clk),
    .rst        (rst),
    .ale        (ale),
    .io_mem     (io_mem),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .hit        (hit),
    .ram_sel_n  (ram_sel_n),
    .bank_sel_n (bank_sel_n),
    .boot_sel_n (boot_sel_n),
    .mem_rd_n   (mem_rd_n),
    .mem_wr_n   (mem_wr_n)
  );

  assign lat_addr = addr_q;

endmodule

// File: tb/busmem_select_bench.sv
module busmem_select_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ale = 1'b0;
  logic        io_mem = 1'b0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [7:0]  ad_lo = '0;
  logic [11:0] a_hi = '0;

  logic [19:0] f_lat, p_lat;
  logic [17:0] f_ram_addr, p_ram_addr;
  logic [13:0] f_rom, p_rom;
  logic        f_ram, p_ram, f_boot, p_boot, f_rd, p_rd, f_wr, p_wr;
  logic [7:0]  f_bank, p_bank;

  always #5 clk = ~clk;

  busmem_select #(.PARTIAL_DECODE(1'b0)) u_busmem_select (
    .clk(clk), .rst(rst), .ale(ale), .ad_lo(ad_lo), .a_hi(a_hi),
    .io_mem(io_mem), .rd_n(rd_n), .wr_n(wr_n),
    .lat_addr(f_lat), .ram_addr(f_ram_addr), .rom_offset(f_rom),
    .ram_sel_n(f_ram), .bank_sel_n(f_bank), .boot_sel_n(f_boot),
    .mem_rd_n(f_rd), .mem_wr_n(f_wr));

  busmem_select #(.PARTIAL_DECODE(1'b1)) u_busmem_select_part (
    .clk(clk), .rst(rst), .ale(ale), .ad_lo(ad_lo), .a_hi(a_hi),
    .io_mem(io_mem), .rd_n(rd_n), .wr_n(wr_n),
    .lat_addr(p_lat), .ram_addr(p_ram_addr), .rom_offset(p_rom),
    .ram_sel_n(p_ram), .bank_sel_n(p_bank), .boot_sel_n(p_boot),
    .mem_rd_n(p_rd), .mem_wr_n(p_wr));

  typedef struct {
    bit          part;
    string       req;
    logic [63:0] vec;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Expected outputs, active-high selects, packed as ram,bank,boot,rd,wr,lat,ram_addr,rom.
  function automatic exp_t model(bit part, logic [19:0] a, bit io, bit rd, bit wr,
                                 bit live, string req);
    exp_t        e;
    bit          go, en, ram, boot;
    logic [7:0]  bank;
    logic [17:0] ra;
    go   = live && !io && (rd || wr);
    en   = part ? (a[19] && !a[17]) : (a[19:17] == 3'b100);
    ram  = go && (a[19:18] == 2'b00);
    bank = (go && en) ? (8'b1 << a[16:14]) : 8'h00;
    boot = go && (part ? (&a[18:14]) : (&a[19:14]));
    ra   = part ? {2'b00, a[15:0]} : a[17:0];
    e.part = part;
    e.req  = req;
    e.vec  = {ram, bank, boot, live && !io && rd, live && !io && wr, a, ra, a[13:0]};
    return e;
  endfunction

  task automatic push2(logic [19:0] a, bit io, bit rd, bit wr, bit live, string req);
    exp_q.push_back(model(1'b0, a, io, rd, wr, live, req));
    exp_q.push_back(model(1'b1, a, io, rd, wr, live, req));
    -> chk_ev;
  endtask

  // Monitor: pops expectations and compares against the matching instance.
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t        e;
        logic [63:0] act;
        e = exp_q.pop_front();
        if (e.part)
          act = {~p_ram, ~p_bank, ~p_boot, ~p_rd, ~p_wr, p_lat, p_ram_addr, p_rom};
        else
          act = {~f_ram, ~f_bank, ~f_boot, ~f_rd, ~f_wr, f_lat, f_ram_addr, f_rom};
        n_vec++;
        if (act !== e.vec) begin
          n_bad++;
          $display("FAIL %s (%s decode): got %h expected %h", e.req,
                   e.part ? "partial" : "full", act, e.vec);
        end
      end
    end
  end

  // Driver: address phase, data phase with garbage on the bus, then idle.
  task automatic bus_cycle(logic [19:0] a, bit io, bit rd, bit wr, string req);
    @(negedge clk);
    ale = 1'b1; {a_hi, ad_lo} = a; io_mem = io; rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    push2(a, io, 1'b0, 1'b0, 1'b0, "R12");
    ale = 1'b0; ad_lo = ~a[7:0]; a_hi = ~a[19:8]; rd_n = !rd; wr_n = !wr;
    @(negedge clk);
    push2(a, io, rd, wr, 1'b1, req);
    rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    push2(a, io, 1'b0, 1'b0, 1'b0, "R9");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    push2(20'h00000, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    rst = 1'b0;

    bus_cycle(20'h00000, 1'b0, 1'b1, 1'b0, "R3");
    bus_cycle(20'h3FFFF, 1'b0, 1'b0, 1'b1, "R3");
    bus_cycle(20'h10005, 1'b0, 1'b1, 1'b0, "R6");
    bus_cycle(20'h2ABCD, 1'b0, 1'b0, 1'b1, "R6");
    for (int k = 0; k < 8; k++)
      bus_cycle(20'h80123 + 20'(k) * 20'h04000, 1'b0, 1'b1, 1'b0, "R4");
    bus_cycle(20'hA0000, 1'b0, 1'b1, 1'b0, "R4");
    bus_cycle(20'hC4000, 1'b0, 1'b1, 1'b0, "R7");
    bus_cycle(20'hDC055, 1'b0, 1'b0, 1'b1, "R7");
    bus_cycle(20'hFC000, 1'b0, 1'b1, 1'b0, "R5");
    bus_cycle(20'hFFFFF, 1'b0, 1'b0, 1'b1, "R5");
    bus_cycle(20'h7C010, 1'b0, 1'b1, 1'b0, "R8");
    bus_cycle(20'h00000, 1'b1, 1'b1, 1'b0, "R2");
    bus_cycle(20'hFC000, 1'b1, 1'b0, 1'b1, "R2");
    bus_cycle(20'h80000, 1'b0, 1'b0, 1'b0, "R9");
    bus_cycle(20'h5A5A5, 1'b0, 1'b1, 1'b0, "R10");
    bus_cycle(20'h3C000, 1'b0, 1'b1, 1'b1, "R11");

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule